// File: doc/BRIEF.md
# Register-Mapped SPI Master with Word FIFOs

This block is a full-duplex SPI master that software drives through a small 32-bit register bus. Software puts it in a setup mode to program the bit period, the word size (8 or 16 bits), the idle clock level, the sampling phase and the bit order. It then switches to a run mode. In run mode every word written to the data register is queued in a four-word transmit FIFO and shifted out on the serial lines. The word captured on the input line at the same time lands in a four-word receive FIFO, and reading the data register takes the oldest word from it.

A receive fill threshold of one to four words drives a status flag. An enable bit routes that flag to an interrupt line, so software can send a burst, sleep, and collect the whole reply at once. The status register also shows both FIFO fill levels and whether the serial engine has gone quiet. The register offsets are 0x00 (mode), 0x04 (control A), 0x08 (control B), 0x14 (status) and 0x18 (data).

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the mode register reads 0x40 (setup mode), status reads 0x0000_0004 (idle, both FIFOs empty), control B reads 0x0108 (divider 1, 8-bit words), `irq` is low and `sclk` is 0.
- R2: Mode register bits 7:6 select the mode: 01 is setup and 10 is run. Queued words are shifted only in run mode.
- R3: Writing the mode register with bit 0 set empties both FIFOs by the next cycle.
- R4: Control A bits 0 (clock idle level), 1 (phase) and 2 (bit order) and all of control B take a write only in setup mode. In run mode such writes leave them unchanged. Control A bits 9 and 13:12 are writable in either mode.
- R5: Control B bits 15:8 hold the divider n (a written 0 is stored as 1). Each serial bit lasts n+1 clock cycles.
- R6: Control B bits 4:0 equal to 16 select 16-bit words. Any other value selects 8-bit words, which use only bits 7:0 of the data write and return received words with bits 15:8 zero.
- R7: With phase 0 the input is sampled on the leading clock edge and the output changes on the trailing edge. With phase 1 the output changes on the leading edge and the input is sampled on the trailing edge. Between words `sclk` rests at the idle level set by bit 0.
- R8: Bit order 1 sends and receives the most significant bit first; 0 sends the least significant bit first.
- R9: Each FIFO holds 4 words. A data write pushes the transmit FIFO, and a write to a full transmit FIFO is dropped. A data read pops the receive FIFO; a read of an empty receive FIFO returns 0.
- R10: Status bit 14 is 1 while the receive FIFO holds more words than control A bits 13:12. `irq` equals status bit 14 AND control A bit 9.
- R11: Status bits 13:11 give the transmit fill level, bits 10:8 the receive fill level, and bit 2 is 1 only when no word is being shifted and the transmit FIFO is empty.
- R12: No new word starts while the receive FIFO is full; shifting resumes once a word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Receive threshold interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: an 8-bit divider field, 16-bit maximum words and four-deep FIFOs. With FIFOs this shallow, a full receive queue, the stalled shifter behind it and a dropped fifth transmit write all occur within a handful of words. The divider is set to values from 1 to 4, so odd and even bit periods and the shortest legal period all occur without long runs. A behavioural serial slave in the bench follows every clock edge in all four polarity and phase pairings and in both bit orders.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int unsigned OFF_MODE = 32'h00;
    localparam int unsigned OFF_CTLA = 32'h04;
    localparam int unsigned OFF_CTLB = 32'h08;
    localparam int unsigned OFF_STAT = 32'h14;
    localparam int unsigned OFF_DATA = 32'h18;

    localparam logic [1:0] MODE_SETUP = 2'b01;
    localparam logic [1:0] MODE_RUN   = 2'b10;

    localparam logic [4:0] WIDE_CODE  = 5'd16;
    localparam logic [4:0] NARROW_CODE = 5'd8;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = push_data;
            d.wp        = step(q.wp);
        end
        if (do_pop) begin
            d.rp = step(q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (clear) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DIVW = 8,
    parameter int MAXW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tx_valid,
    input  logic [MAXW-1:0] tx_word,
    input  logic            rx_room,
    input  logic [DIVW-1:0] div,
    input  logic            wide,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            msbf,
    input  logic            miso,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [MAXW-1:0] rx_word,
    output logic            sclk,
    output logic            mosi,
    output logic            busy
);
    localparam int IW     = $clog2(MAXW);
    localparam int NARROW = MAXW / 2;

    typedef struct packed {
        logic            run;
        logic            ph;
        logic [DIVW-1:0] cnt;
        logic [IW-1:0]   idx;
        logic            out;
        logic [MAXW-1:0] txw;
        logic [MAXW-1:0] rxw;
    } sh_t;

    sh_t           q, d;
    logic [IW-1:0] last_idx;
    logic [DIVW:0] lead_sum;
    logic [DIVW-1:0] lead_at;

    function automatic logic [IW-1:0] bit_pos(input logic [IW-1:0] k,
                                              input logic m, input logic w);
        logic [IW-1:0] top;
        top = w ? IW'(MAXW - 1) : IW'(NARROW - 1);
        return m ? (top - k) : k;
    endfunction

    always_comb begin
        last_idx = wide ? IW'(MAXW - 1) : IW'(NARROW - 1);
        lead_sum = {1'b0, div} + {{DIVW{1'b0}}, 1'b1};
        lead_at  = lead_sum[DIVW:1] - DIVW'(1);
        d        = q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        if (!q.run) begin
            d.ph = 1'b0;
            if (enable && tx_valid && rx_room) begin
                d.run  = 1'b1;
                d.cnt  = '0;
                d.idx  = '0;
                d.txw  = tx_word;
                d.rxw  = '0;
                tx_pop = 1'b1;
                if (!cpha) d.out = tx_word[bit_pos('0, msbf, wide)];
            end
        end else begin
            d.cnt = q.cnt + DIVW'(1);
            if (q.cnt == lead_at) begin
                d.ph = 1'b1;
                if (cpha) d.out = q.txw[bit_pos(q.idx, msbf, wide)];
                else      d.rxw[bit_pos(q.idx, msbf, wide)] = miso;
            end
            if (q.cnt == div) begin
                d.ph  = 1'b0;
                d.cnt = '0;
                if (cpha) d.rxw[bit_pos(q.idx, msbf, wide)] = miso;
                if (q.idx == last_idx) begin
                    d.run   = 1'b0;
                    rx_push = 1'b1;
                end else begin
                    d.idx = q.idx + IW'(1);
                    if (!cpha) d.out = q.txw[bit_pos(q.idx + IW'(1), msbf, wide)];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word = d.rxw;
    assign sclk    = cpol ^ q.ph;
    assign mosi    = q.out;
    assign busy    = q.run;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int DIVW  = 8,
    parameter int MAXW  = 16,
    parameter int DEPTH = 4,
    parameter int ADDRW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [ADDRW-1:0] reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]      mode;
        logic            cpol;
        logic            cpha;
        logic            msbf;
        logic            ie;
        logic [1:0]      thr;
        logic [DIVW-1:0] div;
        logic            wide;
    } ctl_t;

    ctl_t q, d;

    logic            wr_en, rd_en, setup_mode, active, clr_req;
    logic            tx_push, rx_pop, thr_hit, idle;
    logic            sh_tx_pop, sh_rx_push, sh_busy;
    logic [MAXW-1:0] sh_rx_word, tx_head, rx_head;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_empty, tx_full, rx_empty, rx_full;
    logic            cur_cpol;
    logic [DIVW-1:0] cur_div;
    logic [31:0]     stat;
    logic            unused_bits;

    assign wr_en      = reg_en && reg_we;
    assign rd_en      = reg_en && !reg_we;
    assign setup_mode = (q.mode == MODE_SETUP);
    assign active     = (q.mode == MODE_RUN);
    assign cur_cpol   = q.cpol;
    assign cur_div    = q.div;
    assign unused_bits = ^{reg_wdata[31:16], tx_full};

    always_comb begin
        d       = q;
        clr_req = 1'b0;
        tx_push = 1'b0;
        if (wr_en) begin
            case (reg_addr)
                ADDRW'(OFF_MODE): begin
                    d.mode  = reg_wdata[7:6];
                    clr_req = reg_wdata[0];
                end
                ADDRW'(OFF_CTLA): begin
                    d.ie  = reg_wdata[9];
                    d.thr = reg_wdata[13:12];
                    if (setup_mode) begin
                        d.cpol = reg_wdata[0];
                        d.cpha = reg_wdata[1];
                        d.msbf = reg_wdata[2];
                    end
                end
                ADDRW'(OFF_CTLB): begin
                    if (setup_mode) begin
                        d.div  = (reg_wdata[8 +: DIVW] == '0) ? DIVW'(1)
                                                               : reg_wdata[8 +: DIVW];
                        d.wide = (reg_wdata[4:0] == WIDE_CODE);
                    end
                end
                ADDRW'(OFF_DATA): tx_push = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= MODE_SETUP;
            q.div  <= DIVW'(1);
        end else begin
            q <= d;
        end
    end

    assign rx_pop  = rd_en && (reg_addr == ADDRW'(OFF_DATA));
    assign thr_hit = (rx_cnt > CW'(q.thr));
    assign idle    = !sh_busy && tx_empty;
    assign irq     = thr_hit && q.ie;

    always_comb begin
        stat        = '0;
        stat[14]    = thr_hit;
        stat[13:11] = 3'(tx_cnt);
        stat[10:8]  = 3'(rx_cnt);
        stat[2]     = idle;
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            case (reg_addr)
                ADDRW'(OFF_MODE): reg_rdata[7:6] = q.mode;
                ADDRW'(OFF_CTLA): begin
                    reg_rdata[0]     = q.cpol;
                    reg_rdata[1]     = q.cpha;
                    reg_rdata[2]     = q.msbf;
                    reg_rdata[9]     = q.ie;
                    reg_rdata[13:12] = q.thr;
                end
                ADDRW'(OFF_CTLB): begin
                    reg_rdata[8 +: DIVW] = q.div;
                    reg_rdata[4:0]       = q.wide ? WIDE_CODE : NARROW_CODE;
                end
                ADDRW'(OFF_STAT): reg_rdata = stat;
                ADDRW'(OFF_DATA): reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
                default: ;
            endcase
        end
    end

    spim_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear(clr_req),
        .push(tx_push), .push_data(reg_wdata[MAXW-1:0]), .pop(sh_tx_pop),
        .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear(clr_req),
        .push(sh_rx_push), .push_data(sh_rx_word), .pop(rx_pop),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    spim_shifter #(.DIVW(DIVW), .MAXW(MAXW)) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(active),
        .tx_valid(!tx_empty), .tx_word(tx_head), .rx_room(!rx_full),
        .div(q.div), .wide(q.wide), .cpol(q.cpol), .cpha(q.cpha), .msbf(q.msbf),
        .miso(miso), .tx_pop(sh_tx_pop), .rx_push(sh_rx_push), .rx_word(sh_rx_word),
        .sclk(sclk), .mosi(mosi), .busy(sh_busy)
    );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int DEPTH = 4,
    parameter int DIVW  = 8,
    parameter int CW    = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            active,
    input logic            clr_req,
    input logic            busy,
    input logic            sclk,
    input logic            cpol,
    input logic            irq,
    input logic [CW-1:0]   tx_cnt,
    input logic [CW-1:0]   rx_cnt,
    input logic            rx_full,
    input logic            tx_pop,
    input logic [DIVW-1:0] div
);
    assert_run_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> active);

    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (tx_cnt == '0 && rx_cnt == '0));

    assert_setup_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(div));

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    assert_irq_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_cnt != '0));

    assert_no_start_when_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !rx_full);
endmodule

bind spi_fifo_master spim_checker #(.DEPTH(DEPTH), .DIVW(DIVW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .clr_req(clr_req),
    .busy(sh_busy), .sclk(sclk), .cpol(cur_cpol), .irq(irq),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_full(rx_full),
    .tx_pop(sh_tx_pop), .div(cur_div)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
    localparam logic [7:0] A_MODE = 8'h00, A_CTLA = 8'h04, A_CTLB = 8'h08,
                           A_STAT = 8'h14, A_DATA = 8'h18;

    logic        clk = 1'b0, rst_n = 1'b0, reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;

    always #2 clk = ~clk;

    spi_fifo_master uut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int checks = 0, fails = 0;

    bit m_cpol = 0, m_cpha = 0, m_msb = 0, m_wide = 0, b_ie = 0;
    int m_div = 1, b_thr = 0;
    logic [15:0] exp_mosi[$], slave_tx[$], exp_rx[$];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int nbits();
        return m_wide ? 16 : 8;
    endfunction

    function automatic int pos(input int k);
        return m_msb ? (nbits() - 1 - k) : k;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic send(input logic [15:0] w);
        logic [15:0] mask, s;
        mask = m_wide ? 16'hFFFF : 16'h00FF;
        s = ((w ^ 16'hC3A5) + 16'h0101) & mask;
        exp_mosi.push_back(w & mask);
        slave_tx.push_back(s);
        exp_rx.push_back(s);
        wr(A_DATA, {16'h0, w});
    endtask

    task automatic recv(input string tag);
        logic [31:0] v;
        rd(A_DATA, v);
        if (exp_rx.size() > 0) chk(tag, v, exp_rx.pop_front());
        else chk({tag, " (no word expected)"}, v, 0);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            rd(A_STAT, v);
            n++;
        end while (!v[2] && n < 5000);
    endtask

    task automatic setup(input bit cp, input bit ph, input bit msb, input bit wide, input int dv);
        wr(A_MODE, 32'h40);
        m_cpol = cp; m_cpha = ph; m_msb = msb; m_wide = wide;
        m_div = (dv == 0) ? 1 : dv;
        wr(A_CTLA, (b_thr << 12) | (int'(b_ie) << 9) | (int'(msb) << 2) | (int'(ph) << 1) | int'(cp));
        wr(A_CTLB, (dv << 8) | (wide ? 16 : 8));
        wr(A_MODE, 32'h80);
    endtask

    // Behavioural serial slave, evaluated every clock away from the active edge
    logic        prev_sclk = 1'b0, in_bit = 1'b0;
    int          k = 0, cyc = 0, last_lead = 0;
    logic [15:0] cap = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk !== prev_sclk) begin
                if (sclk != m_cpol) begin
                    if (k > 0) chk("R5 bit period in cycles", cyc - last_lead, m_div + 1);
                    last_lead = cyc;
                    in_bit = 1'b1;
                    if (!m_cpha) cap[pos(k)] = mosi;
                    else if (slave_tx.size() > 0) miso = slave_tx[0][pos(k)];
                end else if (in_bit) begin
                    in_bit = 1'b0;
                    if (m_cpha) cap[pos(k)] = mosi;
                    k++;
                    if (k == nbits()) begin
                        if (exp_mosi.size() > 0) chk("R7/R8 serial output word", cap, exp_mosi.pop_front());
                        else chk("R2 unexpected serial word", cap, 16'hxxxx);
                        if (slave_tx.size() > 0) void'(slave_tx.pop_front());
                        k = 0;
                        cap = '0;
                    end else if (!m_cpha && slave_tx.size() > 0) begin
                        miso = slave_tx[0][pos(k)];
                    end
                end
            end
            prev_sclk = sclk;
            if (!m_cpha && k == 0 && slave_tx.size() > 0) miso = slave_tx[0][pos(0)];
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", wd);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, v); chk("R1 mode after reset", v, 32'h40);
        rd(A_STAT, v); chk("R1 status after reset", v, 32'h4);
        rd(A_CTLB, v); chk("R1 control B after reset", v, 32'h0108);
        chk("R1 irq after reset", irq, 0);
        chk("R1 sclk after reset", sclk, 0);

        // Mode 0, MSB first, 8-bit, divider 3; narrow words keep the low byte (R6)
        setup(0, 0, 1, 0, 3);
        send(16'h003C); send(16'h01A5); send(16'h0080);
        wait_idle();
        rd(A_STAT, v); chk("R11 status after three words", v, 32'h4304);
        chk("R10 irq masked when disabled", irq, 0);
        recv("R6 narrow rx word 0"); recv("R7 rx word 1"); recv("R8 rx word 2");
        rd(A_DATA, v); chk("R9 empty read returns 0", v, 0);

        // R4 setup-only fields ignored in run mode
        wr(A_CTLB, 32'h0910);
        rd(A_CTLB, v); chk("R4 control B locked in run mode", v, 32'h0308);
        b_ie = 1; b_thr = 2;
        wr(A_CTLA, 32'h2203);
        rd(A_CTLA, v); chk("R4 control A partial write in run mode", v, 32'h2204);

        // R10 threshold of three words
        send(16'h0011); send(16'h0022);
        wait_idle();
        rd(A_STAT, v); chk("R10 flag below threshold", v[14], 0);
        chk("R10 irq below threshold", irq, 0);
        send(16'h0033);
        wait_idle();
        rd(A_STAT, v); chk("R10 flag at threshold", v[14], 1);
        chk("R10 irq at threshold", irq, 1);
        recv("R10 rx a"); recv("R10 rx b"); recv("R10 rx c");
        chk("R10 irq after drain", irq, 0);

        // R12 stall while receive FIFO is full
        send(16'h0041); send(16'h0042); send(16'h0043); send(16'h0044);
        wait_idle();
        send(16'h0045);
        repeat (200) @(negedge clk);
        rd(A_STAT, v); chk("R12 stalled status", v, 32'h4C00);
        chk("R12 sclk at rest while stalled", sclk, 0);
        recv("R12 rx first");
        wait_idle();
        rd(A_STAT, v); chk("R12 resumed, rx level", v[10:8], 4);
        recv("R12 rx 2"); recv("R12 rx 3"); recv("R12 rx 4"); recv("R12 rx 5");

        // R2 no shifting in setup mode, R9 full drop, R3 clear
        wr(A_MODE, 32'h40);
        for (int i = 0; i < 5; i++) wr(A_DATA, 32'h55 + i);
        repeat (50) @(negedge clk);
        rd(A_STAT, v); chk("R2/R9 setup mode holds four words", v, 32'h2000);
        wr(A_MODE, 32'h41);
        rd(A_STAT, v); chk("R3 clear empties FIFOs", v, 32'h4);
        rd(A_MODE, v); chk("R2 mode field readback", v, 32'h40);

        // Mode 3, LSB first, 16-bit, divider 0 stored as 1
        setup(1, 1, 0, 1, 0);
        rd(A_CTLB, v); chk("R5 divider zero stored as one", v, 32'h0110);
        chk("R7 idle level high", sclk, 1);
        send(16'hBEEF); send(16'h1234);
        wait_idle();
        recv("R6 wide rx 0"); recv("R8 lsb-first rx 1");

        // Mode 1, MSB first, 8-bit, odd period of 5 cycles
        setup(0, 1, 1, 0, 4);
        send(16'h00F0); send(16'h000F); send(16'h0069);
        wait_idle();
        recv("R7 phase1 rx 0"); recv("R7 phase1 rx 1"); recv("R7 phase1 rx 2");

        // Mode 2, MSB first, 16-bit, divider 2
        setup(1, 0, 1, 1, 2);
        send(16'h8001); send(16'h7FFE);
        wait_idle();
        recv("R7 pol1 rx 0"); recv("R7 pol1 rx 1");

        chk("R9 all serial words observed", exp_mosi.size(), 0);
        summary();
        $finish;
    end
endmodule